// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register store of a processor core with several operating modes. It holds sixteen 32-bit architectural registers. Registers 0 to 7 and 15 have a single copy that every mode shares. The upper registers are duplicated per mode. The fast-interrupt mode has its own registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have their own registers 13 and 14, and they share registers 8 to 12 with user mode. System mode uses the user copies throughout. A 5-bit mode code that names no valid mode resolves to an empty bank, whose upper registers read as zero.

The block keeps the current mode in a register that loads on a strobe. There is one write port and two combinational read ports. Each port either follows the current mode or names a mode of its own through an override field. Because every bank has its own physical storage, a mode change only moves the selection pointer and copies nothing. The block also holds one saved-status word for each mode that owns one. A saved-status read aimed at a mode without one returns the status word supplied on the status input.

Top module: `banked_regfile`

## Requirements
- R1: On synchronous reset every register copy and every saved-status word clears to zero, and the current mode becomes supervisor (code 19).
- R2: Mode codes resolve to banks as follows: user for 0, 16 and 31 (31 is system, which uses the user copies); fast-interrupt for 1 and 17; interrupt for 2 and 18; supervisor for 3 and 19; abort for 23; undefined for 27. Every other code resolves to the empty bank.
- R3: Registers 0 to 7 and register 15 have one copy that every mode code reaches, the empty bank included.
- R4: The fast-interrupt bank has private registers 8 to 14, separate from every other bank.
- R5: The interrupt, supervisor, abort and undefined banks each have private registers 13 and 14, and reach the user copies of registers 8 to 12.
- R6: A port whose override flag is 0 uses the current mode. A port whose override flag is 1 reaches the copy that belongs to its named mode, whatever the current mode is.
- R7: In the empty bank, registers 8 to 14 read as zero, and writes to them are dropped without touching any other copy.
- R8: The fast-interrupt, interrupt, supervisor, abort and undefined banks each store one saved-status word. A saved-status read for a user, system or empty-bank code returns the status input unchanged, and a saved-status write for such a code is ignored.
- R9: Changing the mode between two codes of the same bank leaves every visible register value unchanged.
- R10: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R11: A mode load strobe makes the new code current from the next clock edge. Without the strobe the current mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeLoad | input | 1 | Load modeNext into the current mode |
| modeNext | input | 5 | Mode code to load |
| curMode | output | 5 | Current mode code |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register number to write |
| wrOvr | input | 1 | 1: write uses wrMode, 0: write uses the current mode |
| wrMode | input | 5 | Mode code for an overridden write |
| wrData | input | 32 | Write data |
| rdAIdx | input | 4 | Register number for read port A |
| rdAOvr | input | 1 | 1: port A uses rdAMode |
| rdAMode | input | 5 | Mode code for port A |
| rdAData | output | 32 | Read port A data |
| rdBIdx | input | 4 | Register number for read port B |
| rdBOvr | input | 1 | 1: port B uses rdBMode |
| rdBMode | input | 5 | Mode code for port B |
| rdBData | output | 32 | Read port B data |
| statusIn | input | 32 | Current status word, returned for modes without a saved copy |
| savedWrEn | input | 1 | Saved-status write enable |
| savedWrMode | input | 5 | Mode code whose saved-status word is written |
| savedWrData | input | 32 | Saved-status write data |
| savedRdMode | input | 5 | Mode code whose saved-status word is read |
| savedRdData | output | 32 | Saved-status read data |

## Verification
A wrong bank decode or slot mapping shows up as aliasing. A value written under one mode code appears, or fails to appear, when the same register number is read under another code. That error is visible on the very next read after the write. The bench therefore writes a distinct value through every mode code and register number. It then reads back every combination on both ports against a model that groups the codes into banks. Errors in the mode register or the saved-status mux show on curMode or savedRdData one cycle after the offending strobe.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int MODE_W     = 5;
  localparam int IDX_W      = 4;
  localparam int LOW_REGS   = 8;                    // registers shared by all modes
  localparam int HI_REGS    = 7;                    // registers 8..14
  localparam int PRIV_BANKS = 4;                    // banks with private 13/14 only
  localparam int PRIV_REGS  = 2;
  localparam int SLOT_COUNT = LOW_REGS + 1 + 2 * HI_REGS + PRIV_BANKS * PRIV_REGS;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);
  localparam int SAVED_COUNT = 1 + PRIV_BANKS;
  localparam int SAVED_W    = $clog2(SAVED_COUNT);
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_DUM
  } bank_e;

  typedef struct packed {
    logic              zero;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  typedef struct packed {
    logic               has;
    logic [SAVED_W-1:0] idx;
  } saved_t;

  typedef struct packed {
    logic               wrGo;
    logic [SLOT_W-1:0]  wrSlot;
    logic               rdAZero;
    logic [SLOT_W-1:0]  rdASlot;
    logic               rdBZero;
    logic [SLOT_W-1:0]  rdBSlot;
    logic               svWrGo;
    logic [SAVED_W-1:0] svWrIdx;
    logic               svRdHas;
    logic [SAVED_W-1:0] svRdIdx;
  } strobes_t;

  function automatic bank_e modeToBank(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0, 5'd16: b = BK_USR;
      5'd1, 5'd17: b = BK_FIQ;
      5'd2, 5'd18: b = BK_IRQ;
      5'd3, 5'd19: b = BK_SVC;
      5'd23:       b = BK_ABT;
      5'd27:       b = BK_UND;
      5'd31:       b = BK_SYS;
      default:     b = BK_DUM;
    endcase
    return b;
  endfunction

  // Slot layout: 0..7 low regs, 8 reg15, 9..15 user 8..14,
  // 16..22 fast-interrupt 8..14, 23..30 private 13/14 pairs.
  function automatic slot_t mapSlot(input bank_e b, input logic [IDX_W-1:0] idx);
    slot_t r;
    logic [SLOT_W-1:0] base;
    r = '0;
    base = '0;
    case (b)
      BK_IRQ:  base = 5'd23;
      BK_SVC:  base = 5'd25;
      BK_ABT:  base = 5'd27;
      BK_UND:  base = 5'd29;
      default: base = '0;
    endcase
    if (idx < 4'd8) begin
      r.slot = SLOT_W'(idx);
    end else if (idx == 4'd15) begin
      r.slot = 5'd8;
    end else if (b == BK_DUM) begin
      r.zero = 1'b1;
    end else if (b == BK_FIQ) begin
      r.slot = SLOT_W'(idx) + 5'd8;
    end else if (idx >= 4'd13 && base != '0) begin
      r.slot = base + SLOT_W'(idx - 4'd13);
    end else begin
      r.slot = SLOT_W'(idx) + 5'd1;
    end
    return r;
  endfunction

  function automatic saved_t mapSaved(input bank_e b);
    saved_t s;
    s.has = 1'b1;
    case (b)
      BK_FIQ:  s.idx = 3'd0;
      BK_IRQ:  s.idx = 3'd1;
      BK_SVC:  s.idx = 3'd2;
      BK_ABT:  s.idx = 3'd3;
      BK_UND:  s.idx = 3'd4;
      default: begin s.has = 1'b0; s.idx = 3'd0; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mbrf_ctrl.sv
module mbrf_ctrl
  import mbrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeNext,
  output logic [MODE_W-1:0] curMode,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrOvr,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [IDX_W-1:0]  rdAIdx,
  input  logic              rdAOvr,
  input  logic [MODE_W-1:0] rdAMode,
  input  logic [IDX_W-1:0]  rdBIdx,
  input  logic              rdBOvr,
  input  logic [MODE_W-1:0] rdBMode,
  input  logic              savedWrEn,
  input  logic [MODE_W-1:0] savedWrMode,
  input  logic [MODE_W-1:0] savedRdMode,
  output strobes_t          st
);

  logic [MODE_W-1:0] modeQ;
  logic [MODE_W-1:0] wrEff, rdAEff, rdBEff;
  slot_t  wrMap, rdAMap, rdBMap;
  saved_t svWrMap, svRdMap;

  always_ff @(posedge clk) begin
    if (rst)           modeQ <= RESET_MODE;
    else if (modeLoad) modeQ <= modeNext;
  end
  assign curMode = modeQ;

  assign wrEff  = wrOvr  ? wrMode  : modeQ;
  assign rdAEff = rdAOvr ? rdAMode : modeQ;
  assign rdBEff = rdBOvr ? rdBMode : modeQ;

  always_comb begin
    wrMap   = mapSlot(modeToBank(wrEff),  wrIdx);
    rdAMap  = mapSlot(modeToBank(rdAEff), rdAIdx);
    rdBMap  = mapSlot(modeToBank(rdBEff), rdBIdx);
    svWrMap = mapSaved(modeToBank(savedWrMode));
    svRdMap = mapSaved(modeToBank(savedRdMode));
    st.wrGo    = wrEn & ~wrMap.zero;
    st.wrSlot  = wrMap.slot;
    st.rdAZero = rdAMap.zero;
    st.rdASlot = rdAMap.slot;
    st.rdBZero = rdBMap.zero;
    st.rdBSlot = rdBMap.slot;
    st.svWrGo  = savedWrEn & svWrMap.has;
    st.svWrIdx = svWrMap.idx;
    st.svRdHas = svRdMap.has;
    st.svRdIdx = svRdMap.idx;
  end

  // R1: supervisor mode right after reset
  p_reset_mode_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> curMode == RESET_MODE);
  // R11: load takes effect next edge
  p_mode_load_r11: assert property (@(posedge clk) disable iff (rst)
    modeLoad |=> curMode == $past(modeNext));
  // R11: mode holds without a load
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !modeLoad |=> $stable(curMode));
  // R3: low registers always land in their shared slot
  p_shared_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx < 4'd8) |-> (st.wrGo && st.wrSlot == SLOT_W'(wrIdx)));
  // R7: overridden write to empty-bank upper register is dropped
  p_dummy_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrOvr && modeToBank(wrMode) == BK_DUM && wrIdx >= 4'd8 && wrIdx <= 4'd14)
      |-> !st.wrGo);

endmodule

// File: rtl/mbrf_data.sv
module mbrf_data
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] savedWrData,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] rdAData,
  output logic [DATA_W-1:0] rdBData,
  output logic [DATA_W-1:0] savedRdData
);

  logic [DATA_W-1:0] slotQ  [SLOT_COUNT];
  logic [DATA_W-1:0] savedQ [SAVED_COUNT];

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                         slotQ[i] <= '0;
      else if (st.wrGo && st.wrSlot == SLOT_W'(i))     slotQ[i] <= wrData;
    end
    // R9: a slot changes only when written
    p_slot_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(st.wrGo && st.wrSlot == SLOT_W'(i)) |=> $stable(slotQ[i]));
  end

  for (genvar j = 0; j < SAVED_COUNT; j++) begin : g_saved
    always_ff @(posedge clk) begin
      if (rst)                                          savedQ[j] <= '0;
      else if (st.svWrGo && st.svWrIdx == SAVED_W'(j))  savedQ[j] <= savedWrData;
    end
    // R8: a saved word changes only when its own write strobe fires
    p_saved_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(st.svWrGo && st.svWrIdx == SAVED_W'(j)) |=> $stable(savedQ[j]));
  end

  assign rdAData     = st.rdAZero ? '0 : slotQ[st.rdASlot];
  assign rdBData     = st.rdBZero ? '0 : slotQ[st.rdBSlot];
  assign savedRdData = st.svRdHas ? savedQ[st.svRdIdx] : statusIn;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeLoad,
  input  logic [4:0]        modeNext,
  output logic [4:0]        curMode,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic              wrOvr,
  input  logic [4:0]        wrMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        rdAIdx,
  input  logic              rdAOvr,
  input  logic [4:0]        rdAMode,
  output logic [DATA_W-1:0] rdAData,
  input  logic [3:0]        rdBIdx,
  input  logic              rdBOvr,
  input  logic [4:0]        rdBMode,
  output logic [DATA_W-1:0] rdBData,
  input  logic [DATA_W-1:0] statusIn,
  input  logic              savedWrEn,
  input  logic [4:0]        savedWrMode,
  input  logic [DATA_W-1:0] savedWrData,
  input  logic [4:0]        savedRdMode,
  output logic [DATA_W-1:0] savedRdData
);

  strobes_t st;

  mbrf_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .modeLoad(modeLoad), .modeNext(modeNext), .curMode(curMode),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrOvr(wrOvr), .wrMode(wrMode),
    .rdAIdx(rdAIdx), .rdAOvr(rdAOvr), .rdAMode(rdAMode),
    .rdBIdx(rdBIdx), .rdBOvr(rdBOvr), .rdBMode(rdBMode),
    .savedWrEn(savedWrEn), .savedWrMode(savedWrMode), .savedRdMode(savedRdMode),
    .st(st)
  );

  mbrf_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .st(st),
    .wrData(wrData), .savedWrData(savedWrData), .statusIn(statusIn),
    .rdAData(rdAData), .rdBData(rdBData), .savedRdData(savedRdData)
  );

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeLoad = 0;
  logic [4:0]  modeNext = 0;
  logic [4:0]  curMode;
  logic        wrEn = 0;
  logic [3:0]  wrIdx = 0;
  logic        wrOvr = 0;
  logic [4:0]  wrMode = 0;
  logic [31:0] wrData = 0;
  logic [3:0]  rdAIdx = 0;
  logic        rdAOvr = 0;
  logic [4:0]  rdAMode = 0;
  logic [31:0] rdAData;
  logic [3:0]  rdBIdx = 0;
  logic        rdBOvr = 0;
  logic [4:0]  rdBMode = 0;
  logic [31:0] rdBData;
  logic [31:0] statusIn = 32'h5A5A_0F0F;
  logic        savedWrEn = 0;
  logic [4:0]  savedWrMode = 0;
  logic [31:0] savedWrData = 0;
  logic [4:0]  savedRdMode = 0;
  logic [31:0] savedRdData;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [600];
  logic [31:0] svModel [6];

  always #4 clk = ~clk;

  banked_regfile u_dut (.*);

  // Group number per mode code: 0 user/system, 1 fast-int, 2 irq, 3 svc, 4 abort, 5 undef, -1 empty
  function automatic int grpOf(int m);
    if (m == 0 || m == 16 || m == 31) return 0;
    if (m == 1 || m == 17) return 1;
    if (m == 2 || m == 18) return 2;
    if (m == 3 || m == 19) return 3;
    if (m == 23) return 4;
    if (m == 27) return 5;
    return -1;
  endfunction

  function automatic int expKey(int m, int idx);
    int g;
    g = grpOf(m);
    if (idx < 8 || idx == 15) return idx;
    if (g < 0) return -1;
    if (g == 1) return 100 + idx;
    if (idx >= 13 && g >= 2) return g * 100 + idx;
    return idx;
  endfunction

  function automatic string reqOf(int m, int idx);
    int k;
    k = expKey(m, idx);
    if (idx < 8 || idx == 15) return "R3";
    if (k < 0) return "R7";
    if (grpOf(m) == 1) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] expRead(int m, int idx);
    int k;
    k = expKey(m, idx);
    return (k < 0) ? 32'h0 : model[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writeReg(bit ovr, int m, int idx, logic [31:0] d);
    wrEn = 1; wrOvr = ovr; wrMode = 5'(m); wrIdx = 4'(idx); wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic loadMode(int m);
    modeLoad = 1; modeNext = 5'(m);
    step();
    modeLoad = 0;
  endtask

  task automatic readBoth(int mA, int mB, int idx);
    rdAOvr = 1; rdAMode = 5'(mA); rdAIdx = 4'(idx);
    rdBOvr = 1; rdBMode = 5'(mB); rdBIdx = 4'(idx);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 600; i++) model[i] = '0;
    for (int i = 0; i < 6; i++) svModel[i] = '0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;

    // R1: reset state
    check("R1 mode", {27'h0, curMode}, 32'd19);
    for (int idx = 0; idx < 16; idx++) begin
      rdAOvr = 0; rdAIdx = 4'(idx); rdBOvr = 1; rdBMode = 5'd17; rdBIdx = 4'(idx);
      #1;
      check("R1 portA", rdAData, 32'h0);
      check("R1 portB", rdBData, 32'h0);
    end
    savedRdMode = 5'd19; #1;
    check("R1 saved", savedRdData, 32'h0);

    // R2..R5, R7: write distinct value via every code and register
    for (int m = 0; m < 32; m++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [31:0] v;
        int k;
        v = 32'hA000_0000 | (m << 8) | idx;
        writeReg(1, m, idx, v);
        k = expKey(m, idx);
        if (k >= 0) model[k] = v;
      end
    end
    for (int m = 0; m < 32; m++) begin
      for (int idx = 0; idx < 16; idx++) begin
        int mb;
        mb = (m + 1) % 32;
        readBoth(m, mb, idx);
        check($sformatf("R2 %s portA m%0d r%0d", reqOf(m, idx), m, idx), rdAData, expRead(m, idx));
        check($sformatf("R2 %s portB m%0d r%0d", reqOf(mb, idx), mb, idx), rdBData, expRead(mb, idx));
      end
    end

    // R10: same-cycle write and read returns old value
    wrEn = 1; wrOvr = 1; wrMode = 5'd0; wrIdx = 4'd4; wrData = 32'hDEAD_BEEF;
    rdAOvr = 1; rdAMode = 5'd2; rdAIdx = 4'd4;
    #1;
    check("R10 old", rdAData, model[4]);
    step();
    wrEn = 0;
    model[4] = 32'hDEAD_BEEF;
    check("R10 new", rdAData, 32'hDEAD_BEEF);

    // R11 + R6: current-mode access
    loadMode(17);
    check("R11 load", {27'h0, curMode}, 32'd17);
    step();
    check("R11 hold", {27'h0, curMode}, 32'd17);
    writeReg(0, 0, 10, 32'h1234_5678);
    model[110] = 32'h1234_5678;
    rdAOvr = 0; rdAIdx = 4'd10; rdBOvr = 1; rdBMode = 5'd0; rdBIdx = 4'd10; #1;
    check("R6 current", rdAData, 32'h1234_5678);
    check("R6 override user", rdBData, model[10]);

    // R9: same-bank mode change
    loadMode(1);
    rdAOvr = 0; rdAIdx = 4'd10; #1;
    check("R9 fiq codes", rdAData, 32'h1234_5678);
    loadMode(3);
    rdAIdx = 4'd13; #1;
    check("R9 svc before", rdAData, model[313]);
    loadMode(19);
    #1;
    check("R9 svc after", rdAData, model[313]);

    // R7: empty bank as current mode
    loadMode(5);
    writeReg(0, 0, 9, 32'hBAD0_0009);
    rdAOvr = 0; rdAIdx = 4'd9; rdBOvr = 1; rdBMode = 5'd0; rdBIdx = 4'd9; #1;
    check("R7 zero read", rdAData, 32'h0);
    check("R7 user intact", rdBData, model[9]);
    rdBMode = 5'd17; #1;
    check("R7 fiq intact", rdBData, model[109]);

    // R8: saved-status words
    for (int m = 0; m < 32; m++) begin
      int g;
      savedWrEn = 1; savedWrMode = 5'(m); savedWrData = 32'h5500_0000 | m;
      step();
      savedWrEn = 0;
      g = grpOf(m);
      if (g >= 1) svModel[g] = 32'h5500_0000 | m;
    end
    for (int m = 0; m < 32; m++) begin
      int g;
      savedRdMode = 5'(m); #1;
      g = grpOf(m);
      check($sformatf("R8 saved m%0d", m), savedRdData, (g >= 1) ? svModel[g] : statusIn);
    end
    statusIn = 32'h0BAD_F00D; savedRdMode = 5'd31; #1;
    check("R8 follows status", savedRdData, 32'h0BAD_F00D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule